// File: doc/BRIEF.md
# PCI Clock Run Controller

This block runs the host side of the mobile PCI clock-stop handshake. While the PCI clock is running, the host drives the shared, open-drain clock-run line low. When the feature is enabled and the bus has been idle long enough, the block stops driving the line and lets it float high. While the line is released, the block can also ask the clock generator to stop the PCI clock, but only if that request is enabled. Any bus master can bring the clock back by pulling the line low. The block then withdraws the stop request first and drives the line low again one clock later.

The line comes in as a raw pin value and passes through a two-flop synchronizer. After each release, the block ignores the synchronized line until the synchronizer has had time to show the line floating high. This keeps the block's own earlier drive from being mistaken for a wake request. The feature-off input returns the block to the clock-running state at the next edge. All outputs are registered.

Top module: `pci_clkrun_ctrl`

## Requirements
- R1: During and right after reset, `clkrun_drive` is 1 (line driven low, clock running) and `clkstop_req` is 0.
- R2: With `clkrun_off` at 0, `clkrun_drive` falls at the edge that samples the 26th consecutive cycle with `bus_idle` at 1. After only 25 such cycles it is still 1.
- R3: A single cycle with `bus_idle` at 0 before the threshold is reached clears the idle count. A full 26 new consecutive idle cycles are then needed.
- R4: `clkstop_req` is 1 only while the line is released and `stop_allow` is 1. It follows a change of `stop_allow` one edge later and is never 1 while `clkrun_drive` is 1.
- R5: Once the line is released and settled, `clkrun_in` going to 0 is handled as follows. `clkstop_req` falls at the third edge after the change. `clkrun_drive` returns to 1 at the fourth edge.
- R6: `clkrun_off` at 1 forces `clkrun_drive` to 1 and `clkstop_req` to 0 at the next edge. It keeps them there whatever `bus_idle` does.
- R7: After a wake, the idle count restarts from zero, and busy cycles keep the line driven.
- R8: For the two synchronizer clocks after a release, `clkrun_in` is ignored, so the still-low synchronized value from the block's own drive does not cause a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| clkrun_off | input | 1 | 1 disables clock-run handling (clock kept running) |
| stop_allow | input | 1 | 1 allows the clock-stop request while released |
| bus_idle | input | 1 | 1 when the PCI bus is idle this cycle |
| clkrun_in | input | 1 | Raw level of the open-drain clock-run line |
| clkrun_drive | output | 1 | 1 = pull the clock-run line low |
| clkstop_req | output | 1 | 1 = ask the clock generator to stop the PCI clock |

## Verification
The bench builds the block with its defaults: a 26-cycle idle threshold and a 2-stage synchronizer. Both values are small, so the exact release edge (25 versus 26 idle cycles), the settle window after a release and the three-edge and four-edge wake latencies can each be checked cycle by cycle. The bench models the line as open-drain, driven low by either the block or a simulated master. The self-induced-wake hazard in R8 therefore appears just as it would on a real line.

// File: rtl/pci_clkrun_pkg.sv
package pci_clkrun_pkg;
  typedef enum logic [1:0] {
    CR_RUN  = 2'd0,   // line driven low, counting idle cycles
    CR_REL  = 2'd1,   // line released, clock may be stopped
    CR_WAKE = 2'd2    // stop request dropped, drive resumes next edge
  } cr_state_e;
endpackage

// File: rtl/pci_clkrun_sync.sv
module pci_clkrun_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pci_clkrun_cnt.sv
module pci_clkrun_cnt #(
  parameter int LIMIT = 26
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic hit
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear || !tick) cnt <= '0;
    else if (cnt != LAST)      cnt <= cnt + 1'b1;
  end

  // asserted on the edge that samples the LIMIT-th consecutive tick
  assign hit = tick && !clear && (cnt == LAST);
endmodule

// File: rtl/pci_clkrun_ctrl.sv
module pci_clkrun_ctrl
  import pci_clkrun_pkg::*;
#(
  parameter int IDLE_CYCLES = 26,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clkrun_off,
  input  logic stop_allow,
  input  logic bus_idle,
  input  logic clkrun_in,
  output logic clkrun_drive,
  output logic clkstop_req
);
  cr_state_e state, nxt;
  logic line_s;
  logic idle_hit;
  logic settle_hit;
  logic armed;

  pci_clkrun_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (clkrun_in),
    .q   (line_s)
  );

  pci_clkrun_cnt #(.LIMIT(IDLE_CYCLES)) u_idle (
    .clk   (clk),
    .rst   (rst),
    .clear ((state != CR_RUN) || clkrun_off),
    .tick  (bus_idle),
    .hit   (idle_hit)
  );

  // waits out the synchronizer latency after a release
  pci_clkrun_cnt #(.LIMIT(SYNC_STAGES)) u_settle (
    .clk   (clk),
    .rst   (rst),
    .clear (state != CR_REL),
    .tick  (1'b1),
    .hit   (settle_hit)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      CR_RUN:  if (idle_hit) nxt = CR_REL;
      CR_REL:  if (armed && !line_s) nxt = CR_WAKE;
      CR_WAKE: nxt = CR_RUN;
      default: nxt = CR_RUN;
    endcase
    if (clkrun_off) nxt = CR_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= CR_RUN;
      clkrun_drive <= 1'b1;
      clkstop_req  <= 1'b0;
      armed        <= 1'b0;
    end else begin
      state        <= nxt;
      clkrun_drive <= (nxt == CR_RUN);
      clkstop_req  <= (nxt == CR_REL) && stop_allow;
      armed        <= (nxt == CR_REL) && (armed || settle_hit);
    end
  end
endmodule

// File: rtl/pci_clkrun_ctrl_chk.sv
module pci_clkrun_ctrl_chk #(
  parameter int IDLE_CYCLES = 26
) (
  input logic clk,
  input logic rst,
  input logic clkrun_off,
  input logic stop_allow,
  input logic bus_idle,
  input logic clkrun_drive,
  input logic clkstop_req
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || !bus_idle || !clkrun_drive || clkrun_off) run_len <= '0;
    else if (run_len != CW'(IDLE_CYCLES)) run_len <= run_len + 1'b1;
  end

  assert_release_after_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(clkrun_drive) |-> (run_len == CW'(IDLE_CYCLES)));

  assert_stop_not_while_driving_R4: assert property (@(posedge clk) disable iff (rst)
    clkstop_req |-> !clkrun_drive);

  assert_stop_needs_allow_R4: assert property (@(posedge clk) disable iff (rst)
    clkstop_req |-> $past(stop_allow));

  assert_stop_drops_before_drive_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(clkrun_drive) && !$past(clkrun_off)) |-> !$past(clkstop_req));

  assert_off_forces_run_R6: assert property (@(posedge clk) disable iff (rst)
    clkrun_off |=> (clkrun_drive && !clkstop_req));
endmodule

bind pci_clkrun_ctrl pci_clkrun_ctrl_chk #(.IDLE_CYCLES(IDLE_CYCLES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .clkrun_off   (clkrun_off),
  .stop_allow   (stop_allow),
  .bus_idle     (bus_idle),
  .clkrun_drive (clkrun_drive),
  .clkstop_req  (clkstop_req)
);

// File: tb/pci_clkrun_ctrl_tb.sv
module pci_clkrun_ctrl_tb;
  logic clk = 1'b0;
  logic rst;
  logic clkrun_off, stop_allow, bus_idle, master_pull;
  logic clkrun_drive, clkstop_req;
  logic line_n;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // open-drain line with pull-up
  assign line_n = !(clkrun_drive || master_pull);

  pci_clkrun_ctrl u_dut (
    .clk          (clk),
    .rst          (rst),
    .clkrun_off   (clkrun_off),
    .stop_allow   (stop_allow),
    .bus_idle     (bus_idle),
    .clkrun_in    (line_n),
    .clkrun_drive (clkrun_drive),
    .clkstop_req  (clkstop_req)
  );

  // {off, allow, idle cycles, expected drive, expected stop}
  localparam logic [11:0] VEC [0:5] = '{
    {1'b0, 1'b0, 8'd25, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'd26, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'd26, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'd25, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'd40, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'd30, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle_running();
    @(negedge clk);
    clkrun_off = 1'b1; bus_idle = 1'b0; master_pull = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle_for(input int n);
    bus_idle = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clkrun_off = 1'b0; stop_allow = 1'b1; bus_idle = 1'b1; master_pull = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 drive in reset", clkrun_drive, 1'b1);
    check("R1 stop in reset", clkstop_req, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 drive after reset", clkrun_drive, 1'b1);

    // table walk: R2 threshold, R4 stop gating, R6 disable, R8 settle window
    for (int i = 0; i < 6; i++) begin
      settle_running();
      clkrun_off = VEC[i][11];
      stop_allow = VEC[i][10];
      idle_for(int'(VEC[i][9:2]));
      check($sformatf("R2/R4/R6/R8 vec%0d drive", i), clkrun_drive, VEC[i][1]);
      check($sformatf("R2/R4/R6/R8 vec%0d stop", i), clkstop_req, VEC[i][0]);
    end

    // R3: busy cycle at count 20 restarts the count
    settle_running();
    clkrun_off = 1'b0; stop_allow = 1'b1;
    idle_for(20);
    bus_idle = 1'b0; @(negedge clk);
    idle_for(25);
    check("R3 still driving after restart+25", clkrun_drive, 1'b1);
    idle_for(1);
    check("R3 released after restart+26", clkrun_drive, 1'b0);
    check("R3 stop after release", clkstop_req, 1'b1);

    // R8: settled, no self wake
    idle_for(5);
    check("R8 no self wake", clkrun_drive, 1'b0);

    // R4: stop follows allow within one edge
    stop_allow = 1'b0; @(negedge clk);
    check("R4 stop drops with allow", clkstop_req, 1'b0);
    check("R4 still released", clkrun_drive, 1'b0);
    stop_allow = 1'b1; @(negedge clk);
    check("R4 stop returns with allow", clkstop_req, 1'b1);

    // R5: master pulls line
    master_pull = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 stop held two edges", clkstop_req, 1'b1);
    @(negedge clk);
    check("R5 stop falls third edge", clkstop_req, 1'b0);
    check("R5 drive not yet back", clkrun_drive, 1'b0);
    @(negedge clk);
    check("R5 drive back fourth edge", clkrun_drive, 1'b1);

    // R7: fresh count after wake, busy keeps driving
    master_pull = 1'b0;
    bus_idle = 1'b0; repeat (3) @(negedge clk);
    check("R7 busy keeps driving", clkrun_drive, 1'b1);
    idle_for(25);
    check("R7 25 idle after wake", clkrun_drive, 1'b1);
    idle_for(1);
    check("R7 26 idle after wake", clkrun_drive, 1'b0);

    // R6: disable while released with stop
    idle_for(4);
    clkrun_off = 1'b1; @(negedge clk);
    check("R6 off forces drive", clkrun_drive, 1'b1);
    check("R6 off drops stop", clkstop_req, 1'b0);
    idle_for(30);
    check("R6 off holds drive", clkrun_drive, 1'b1);

    // R5 with stop disallowed: wake still restores drive
    clkrun_off = 1'b0; stop_allow = 1'b0;
    idle_for(30);
    check("R4 no stop when disallowed", clkstop_req, 1'b0);
    master_pull = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 wake without stop", clkrun_drive, 1'b1);
    master_pull = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule